// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block is the interlock and steering logic for an in-order pipeline with five stages: fetch, decode with register read, execute, memory access and write-back. Each stage holds one instruction per cycle. The program counter advances by one for each instruction. Every cycle the block looks at the two source register numbers of the instruction in decode. It also looks at the destination numbers and write-valid bits of the instructions in execute, memory and write-back, and at the branch that may be resolving in execute. From these it decides whether fetch and decode must hold, whether execute receives a no-op, and whether younger work must be discarded and fetch redirected.

Two parameters choose the variant. With `FORWARD` clear, the block is interlock only: a consumer waits in decode until its producer has left write-back. With `FORWARD` set, results are steered straight into the execute operands, and only a load followed at once by its consumer costs a cycle. With `PREDICT` clear, a branch in decode blocks fetch until the branch resolves in execute. With `PREDICT` set, fetch runs ahead on a guess, and only a wrong guess discards the two younger slots. The operand steering codes are registered, so they belong to the instruction that enters execute on the next edge.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While `rst_n` is low, and after it rises with no decode traffic, both steering codes `byp_a` and `byp_b` read 0 (register file).
- R2: With `FORWARD`=0, a valid decode instruction whose source matches the destination of a writing instruction in execute, memory or write-back raises `pc_hold`, `id_hold` and `ex_bubble`. A producer directly ahead costs three held cycles, and a producer two ahead costs two.
- R3: A source or destination of register 0 never causes a match. A stage whose write-valid bit is low never causes a match.
- R4: With `FORWARD`=1, a dependence on a non-load producer does not hold. On the next edge the code for that operand becomes 1 if the producer was in execute, 2 if it was in memory, 3 if it was in write-back, and 0 if there was no match.
- R5: When several later stages write the same register, the code picks the youngest producer: execute before memory before write-back.
- R6: With `FORWARD`=1, a load in execute whose destination matches a decode source holds decode for exactly one cycle. The next cycle, with the load in memory, there is no hold and the code becomes 2.
- R7: With `PREDICT`=0, a branch in decode that is not data-held raises `pc_hold` and `if_flush`. A branch that is data-held raises `pc_hold`, `id_hold` and `ex_bubble`, and leaves `if_flush` low.
- R8: With `PREDICT`=0, a taken branch in execute raises `redirect`, `if_flush`, `id_flush` and `ex_bubble`, and lowers `pc_hold`. A taken branch costs two discarded fetch slots in total. A not-taken branch costs one slot and raises nothing in execute.
- R9: With `PREDICT`=1, a branch in decode causes no hold. A branch in execute whose outcome differs from its guess raises `redirect`, `if_flush`, `id_flush` and `ex_bubble`, with `id_hold` and `pc_hold` low. A correct guess raises none of these.
- R10: In any cycle where `ex_bubble` is high, both steering codes are 0 after the next edge.
- R11: A decode slot with `id_valid` low never holds and yields codes of 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_src_a | input | REG_W | First source register of the decode instruction (0 = unused) |
| id_src_b | input | REG_W | Second source register of the decode instruction (0 = unused) |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| ex_wr | input | 1 | Execute holds a valid instruction that writes a register |
| ex_dst | input | REG_W | Destination register in execute |
| ex_load | input | 1 | Execute instruction is a load |
| ex_branch | input | 1 | Execute holds a valid branch |
| ex_taken | input | 1 | Resolved outcome of the branch in execute |
| ex_guess | input | 1 | Outcome that was guessed for the branch in execute |
| mem_wr | input | 1 | Memory stage holds a valid register-writing instruction |
| mem_dst | input | REG_W | Destination register in memory stage |
| wb_wr | input | 1 | Write-back holds a valid register-writing instruction |
| wb_dst | input | REG_W | Destination register in write-back |
| pc_hold | output | 1 | Program counter keeps its value |
| id_hold | output | 1 | Decode keeps its instruction |
| ex_bubble | output | 1 | Execute loads a no-op that writes nothing |
| if_flush | output | 1 | The fetched instruction is replaced by a no-op |
| id_flush | output | 1 | The decode instruction is discarded |
| redirect | output | 1 | Fetch loads the resolved branch path |
| byp_a | output | 2 | Steering code for execute operand A: 0 file, 1 memory, 2 write-back, 3 retired |
| byp_b | output | 2 | Steering code for execute operand B, same encoding |

## Verification
The interlock is driven with producers one, two and three slots ahead of the consumer. The held-cycle counts tell the interlock variant apart from the steering variant, and the registered codes show which stage would supply the value. Identical destinations in several stages at once separate youngest-first selection from any other order. Register 0, write-invalid stages and empty decode slots show that they never create matches. Branches are run taken, not taken, correctly guessed and wrongly guessed. The discarded-slot counts and quash flags separate the blocking fetch from the guessing fetch.

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int REG_W   = 5,
  parameter bit FORWARD = 1'b0,
  parameter bit PREDICT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_branch,
  input  logic             ex_wr,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_load,
  input  logic             ex_branch,
  input  logic             ex_taken,
  input  logic             ex_guess,
  input  logic             mem_wr,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             wb_wr,
  input  logic [REG_W-1:0] wb_dst,
  output logic             pc_hold,
  output logic             id_hold,
  output logic             ex_bubble,
  output logic             if_flush,
  output logic             id_flush,
  output logic             redirect,
  output logic [1:0]       byp_a,
  output logic [1:0]       byp_b
);
  localparam logic [1:0] BYP_FILE = 2'd0;
  localparam logic [1:0] BYP_MEM  = 2'd1;
  localparam logic [1:0] BYP_WB   = 2'd2;
  localparam logic [1:0] BYP_RET  = 2'd3;

  function automatic logic hit(input logic wr, input logic [REG_W-1:0] dst,
                               input logic [REG_W-1:0] src);
    return wr && (src != '0) && (dst == src);
  endfunction

  // h = {wb, mem, ex}; youngest producer wins
  function automatic logic [1:0] pick(input logic [2:0] h);
    if (h[0])      return BYP_MEM;
    else if (h[1]) return BYP_WB;
    else if (h[2]) return BYP_RET;
    else           return BYP_FILE;
  endfunction

  logic [2:0] hit_a, hit_b;
  logic       data_hz, mispredict, br_wait;

  assign hit_a = {hit(wb_wr, wb_dst, id_src_a), hit(mem_wr, mem_dst, id_src_a),
                  hit(ex_wr, ex_dst, id_src_a)};
  assign hit_b = {hit(wb_wr, wb_dst, id_src_b), hit(mem_wr, mem_dst, id_src_b),
                  hit(ex_wr, ex_dst, id_src_b)};

  generate
    if (FORWARD) begin : g_fwd
      assign data_hz = id_valid && ex_load && (hit_a[0] || hit_b[0]);
    end else begin : g_interlock
      assign data_hz = id_valid && ((|hit_a) || (|hit_b));
    end

    if (PREDICT) begin : g_guess
      assign mispredict = ex_branch && (ex_taken != ex_guess);
      assign br_wait    = 1'b0;
    end else begin : g_block
      assign mispredict = ex_branch && ex_taken;
      assign br_wait    = id_valid && id_branch;
    end
  endgenerate

  logic spare_unused;
  assign spare_unused = ^{ex_load, ex_guess, id_branch};

  assign redirect  = mispredict;
  assign id_flush  = mispredict;
  assign id_hold   = data_hz && !mispredict;
  assign ex_bubble = id_hold || mispredict;
  assign pc_hold   = (id_hold || br_wait) && !mispredict;
  assign if_flush  = mispredict || (br_wait && !id_hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_a <= BYP_FILE;
      byp_b <= BYP_FILE;
    end else if (ex_bubble || !id_valid || !FORWARD) begin
      byp_a <= BYP_FILE;
      byp_b <= BYP_FILE;
    end else begin
      byp_a <= pick(hit_a);
      byp_b <= pick(hit_b);
    end
  end
endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
  parameter int REG_W   = 5,
  parameter bit FORWARD = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             id_valid,
  input logic [REG_W-1:0] id_src_a,
  input logic [REG_W-1:0] id_src_b,
  input logic             id_branch,
  input logic             ex_wr,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_load,
  input logic             pc_hold,
  input logic             id_hold,
  input logic             ex_bubble,
  input logic             if_flush,
  input logic             id_flush,
  input logic             redirect,
  input logic [1:0]       byp_a,
  input logic [1:0]       byp_b
);
  a_r10_bubble_clears_codes: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |=> (byp_a == 2'd0 && byp_b == 2'd0));

  a_r11_empty_slot_codes: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> (byp_a == 2'd0 && byp_b == 2'd0));

  a_r11_empty_slot_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !id_hold);

  a_r3_reg_zero_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src_a == '0 && id_src_b == '0 && !id_branch) |-> (!id_hold && !pc_hold));

  a_r9_quash_set: assert property (@(posedge clk) disable iff (!rst_n)
    id_flush |-> (redirect && if_flush && ex_bubble && !id_hold && !pc_hold));

  a_r2_interlock_on_ex_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!FORWARD && id_valid && ex_wr && ex_dst != '0 && ex_dst == id_src_a && !id_flush)
      |-> (id_hold && pc_hold && ex_bubble));

  a_r4_no_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    (FORWARD && !ex_load) |-> !id_hold);
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.REG_W(REG_W), .FORWARD(FORWARD)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_src_a(id_src_a),
  .id_src_b(id_src_b), .id_branch(id_branch), .ex_wr(ex_wr), .ex_dst(ex_dst),
  .ex_load(ex_load), .pc_hold(pc_hold), .id_hold(id_hold), .ex_bubble(ex_bubble),
  .if_flush(if_flush), .id_flush(id_flush), .redirect(redirect),
  .byp_a(byp_a), .byp_b(byp_b)
);

// File: tb/pipe_hazard_ctl_bench.sv
`timescale 1ns/1ps
module pipe_hazard_ctl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic       id_valid, id_branch, ex_wr, ex_load, ex_branch, ex_taken, ex_guess, mem_wr, wb_wr;
  logic [4:0] id_src_a, id_src_b, ex_dst, mem_dst, wb_dst;

  logic s_pc, s_idh, s_bub, s_iff, s_idf, s_red;
  logic f_pc, f_idh, f_bub, f_iff, f_idf, f_red;
  logic [1:0] s_ba, s_bb, f_ba, f_bb;

  pipe_hazard_ctl #(.REG_W(5), .FORWARD(1'b0), .PREDICT(1'b0)) u_pipe_hazard_ctl (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_src_a(id_src_a), .id_src_b(id_src_b),
    .id_branch(id_branch), .ex_wr(ex_wr), .ex_dst(ex_dst), .ex_load(ex_load),
    .ex_branch(ex_branch), .ex_taken(ex_taken), .ex_guess(ex_guess), .mem_wr(mem_wr),
    .mem_dst(mem_dst), .wb_wr(wb_wr), .wb_dst(wb_dst), .pc_hold(s_pc), .id_hold(s_idh),
    .ex_bubble(s_bub), .if_flush(s_iff), .id_flush(s_idf), .redirect(s_red),
    .byp_a(s_ba), .byp_b(s_bb));

  pipe_hazard_ctl #(.REG_W(5), .FORWARD(1'b1), .PREDICT(1'b1)) u_pipe_hazard_ctl_fp (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_src_a(id_src_a), .id_src_b(id_src_b),
    .id_branch(id_branch), .ex_wr(ex_wr), .ex_dst(ex_dst), .ex_load(ex_load),
    .ex_branch(ex_branch), .ex_taken(ex_taken), .ex_guess(ex_guess), .mem_wr(mem_wr),
    .mem_dst(mem_dst), .wb_wr(wb_wr), .wb_dst(wb_dst), .pc_hold(f_pc), .id_hold(f_idh),
    .ex_bubble(f_bub), .if_flush(f_iff), .id_flush(f_idf), .redirect(f_red),
    .byp_a(f_ba), .byp_b(f_bb));

  // {pc_hold, id_hold, ex_bubble, if_flush, id_flush, redirect}
  logic [5:0] s_ctl, f_ctl;
  assign s_ctl = {s_pc, s_idh, s_bub, s_iff, s_idf, s_red};
  assign f_ctl = {f_pc, f_idh, f_bub, f_iff, f_idf, f_red};

  localparam logic [5:0] C_NONE  = 6'b000000;
  localparam logic [5:0] C_DATA  = 6'b111000;
  localparam logic [5:0] C_BRID  = 6'b100100;
  localparam logic [5:0] C_QUASH = 6'b001111;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    id_valid = 0; id_branch = 0; id_src_a = 0; id_src_b = 0;
    ex_wr = 0; ex_dst = 0; ex_load = 0; ex_branch = 0; ex_taken = 0; ex_guess = 0;
    mem_wr = 0; mem_dst = 0; wb_wr = 0; wb_dst = 0;
  endtask

  task automatic next();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; idle();
    repeat (3) next();
    #1;
    check("R1 reset codes stall", {4'd0, s_ba, s_bb}, 8'd0);
    check("R1 reset codes fwd", {4'd0, f_ba, f_bb}, 8'd0);
    rst_n = 1;
    next(); next();
    check("R1 after reset", {4'd0, f_ba, f_bb}, 8'd0);
  endtask

  task automatic t_stall_adjacent();
    int bub = 0;
    idle(); id_valid = 1; id_src_a = 5'd3; ex_wr = 1; ex_dst = 5'd3; #1;
    check("R2 ex match", {2'd0, s_ctl}, {2'd0, C_DATA});
    check("R4 fwd no hold", {2'd0, f_ctl}, {2'd0, C_NONE});
    bub += s_bub;
    next(); ex_wr = 0; mem_wr = 1; mem_dst = 5'd3; #1;
    check("R2 mem match", {2'd0, s_ctl}, {2'd0, C_DATA}); bub += s_bub;
    next(); mem_wr = 0; wb_wr = 1; wb_dst = 5'd3; #1;
    check("R2 wb match", {2'd0, s_ctl}, {2'd0, C_DATA}); bub += s_bub;
    next(); wb_wr = 0; #1;
    check("R2 released", {2'd0, s_ctl}, {2'd0, C_NONE}); bub += s_bub;
    check("R2 adjacent bubbles", 8'(bub), 8'd3);
    next(); idle();
  endtask

  task automatic t_stall_gap();
    int bub = 0;
    idle(); id_valid = 1; id_src_b = 5'd7; mem_wr = 1; mem_dst = 5'd7; #1; bub += s_bub;
    next(); mem_wr = 0; wb_wr = 1; wb_dst = 5'd7; #1; bub += s_bub;
    next(); wb_wr = 0; #1; bub += s_bub;
    check("R2 gap bubbles", 8'(bub), 8'd2);
    next(); idle();
  endtask

  task automatic t_zero_invalid();
    idle(); id_valid = 1; ex_wr = 1; ex_dst = 5'd0; mem_wr = 1; mem_dst = 5'd0; #1;
    check("R3 reg0 stall", {2'd0, s_ctl}, {2'd0, C_NONE});
    next();
    check("R3 reg0 code", {4'd0, f_ba, f_bb}, 8'd0);
    idle(); id_valid = 1; id_src_a = 5'd6; ex_dst = 5'd6; mem_dst = 5'd6; #1;
    check("R3 no write valid", {2'd0, s_ctl}, {2'd0, C_NONE});
    next();
    check("R3 no write code", {4'd0, f_ba, f_bb}, 8'd0);
    idle(); id_src_a = 5'd6; ex_wr = 1; ex_dst = 5'd6; ex_load = 1; #1;
    check("R11 empty stall", {2'd0, s_ctl}, {2'd0, C_NONE});
    check("R11 empty fwd", {2'd0, f_ctl}, {2'd0, C_NONE});
    ex_load = 0; id_valid = 0; next();
    check("R11 empty code", {4'd0, f_ba, f_bb}, 8'd0);
    idle();
  endtask

  task automatic t_fwd_codes();
    idle(); id_valid = 1; id_src_a = 5'd9; ex_wr = 1; ex_dst = 5'd9; #1;
    check("R4 ex no hold", {2'd0, f_ctl}, {2'd0, C_NONE});
    next(); check("R4 code ex", {6'd0, f_ba}, 8'd1);
    ex_wr = 0; mem_wr = 1; mem_dst = 5'd9; next();
    check("R4 code mem", {6'd0, f_ba}, 8'd2);
    mem_wr = 0; wb_wr = 1; wb_dst = 5'd9; next();
    check("R4 code wb", {6'd0, f_ba}, 8'd3);
    wb_wr = 0; id_src_b = 5'd12; mem_wr = 1; mem_dst = 5'd12; next();
    check("R4 code none a", {6'd0, f_ba}, 8'd0);
    check("R4 code mem b", {6'd0, f_bb}, 8'd2);
    check("R4 stall mode codes", {4'd0, s_ba, s_bb}, 8'd0);
    idle();
  endtask

  task automatic t_priority();
    idle(); id_valid = 1; id_src_a = 5'd5;
    ex_wr = 1; ex_dst = 5'd5; mem_wr = 1; mem_dst = 5'd5; wb_wr = 1; wb_dst = 5'd5;
    next(); check("R5 ex wins", {6'd0, f_ba}, 8'd1);
    ex_wr = 0; next(); check("R5 mem wins", {6'd0, f_ba}, 8'd2);
    idle();
  endtask

  task automatic t_load_use();
    int held = 0;
    idle(); id_valid = 1; id_src_a = 5'd4; ex_wr = 1; ex_dst = 5'd4; ex_load = 1; #1;
    check("R6 load hold", {2'd0, f_ctl}, {2'd0, C_DATA}); held += f_idh;
    next(); check("R10 code after bubble", {6'd0, f_ba}, 8'd0);
    ex_wr = 0; ex_load = 0; mem_wr = 1; mem_dst = 5'd4; #1;
    check("R6 released", {2'd0, f_ctl}, {2'd0, C_NONE}); held += f_idh;
    next(); check("R6 code mem", {6'd0, f_ba}, 8'd2);
    check("R6 one bubble", 8'(held), 8'd1);
    idle();
  endtask

  task automatic t_branch_block(input bit taken);
    int fl = 0;
    idle(); id_valid = 1; id_branch = 1; id_src_a = 5'd1; id_src_b = 5'd2; #1;
    check("R7 branch in decode", {2'd0, s_ctl}, {2'd0, C_BRID});
    check("R9 guess no hold", {2'd0, f_ctl}, {2'd0, C_NONE});
    fl += s_iff;
    next(); idle(); ex_branch = 1; ex_taken = taken; ex_guess = taken; #1;
    check("R8 resolve", {2'd0, s_ctl}, {2'd0, taken ? C_QUASH : C_NONE});
    check("R9 correct guess", {2'd0, f_ctl}, {2'd0, C_NONE});
    fl += s_iff;
    check("R8 lost slots", 8'(fl), taken ? 8'd2 : 8'd1);
    next(); idle();
  endtask

  task automatic t_branch_held();
    idle(); id_valid = 1; id_branch = 1; id_src_a = 5'd3; mem_wr = 1; mem_dst = 5'd3; #1;
    check("R7 held branch", {2'd0, s_ctl}, {2'd0, C_DATA});
    next(); idle();
  endtask

  task automatic t_mispredict();
    idle(); id_valid = 1; id_src_a = 5'd8; wb_wr = 1; wb_dst = 5'd8;
    ex_branch = 1; ex_taken = 0; ex_guess = 1; #1;
    check("R9 wrong guess", {2'd0, f_ctl}, {2'd0, C_QUASH});
    next(); check("R10 code after quash", {6'd0, f_ba}, 8'd0);
    ex_taken = 1; ex_guess = 0; #1;
    check("R9 wrong guess taken", {2'd0, f_ctl}, {2'd0, C_QUASH});
    check("R8 taken blocking", {2'd0, s_ctl}, {2'd0, C_QUASH});
    ex_taken = 0; ex_guess = 0; #1;
    check("R9 right not taken", {2'd0, f_ctl}, {2'd0, C_NONE});
    next(); idle();
  endtask

  initial begin
    t_reset();
    t_stall_adjacent();
    t_stall_gap();
    t_zero_invalid();
    t_fwd_codes();
    t_priority();
    t_load_use();
    t_branch_block(1'b1);
    t_branch_block(1'b0);
    t_branch_held();
    t_mispredict();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule